// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles presented to a byte-wide flash array and recognises the unlock-prefixed command sequences that software uses to drive it. Every command starts with the same two key writes. A third write selects the operation. Byte program needs one more write, which carries the target address and the data. Chip erase and boot-region lock need three more writes, and those two commands differ only in their final data byte. When a sequence completes, the decoder raises a one-cycle pulse towards the program/erase engine. The program pulse comes with the captured address and data.

The decoder also tracks the identification mode. While that mode is active, reads on a separate read-address port return the manufacturer code, the device code and the boot-region lock status. Writes arrive on a valid/ready handshake. `wr_ready` falls while the engine reports `busy`. A write counts only in a cycle where both `wr_valid` and `wr_ready` are high. A source holding a write during busy keeps it stable until it is accepted.

The boot region covers the lowest or the highest block of the address space, selected by a parameter. A program aimed at that region is dropped while the region is locked, unless the digital override input is high.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is accepted only when `wr_valid` and `wr_ready` are both high. `wr_ready` is the inverse of `busy`. A write offered while `busy` is high changes no state and produces no pulse.
- R2: The writes AA@5555, 55@2AAA, A0@5555 and then any data D at any address X produce `prog_pulse` for one cycle, in the cycle after X is accepted. In that cycle `prog_addr`=X (full width) and `prog_data`=D.
- R3: The writes AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 10@5555 produce `erase_pulse` for one cycle after the last write. `erase_keep_boot` then equals `boot_locked & ~lock_override`, sampled at that last write.
- R4: The same six-write sequence with final data 40 instead of 10 produces `lock_pulse` for one cycle, and no erase pulse.
- R5: Key and opcode writes are matched on address bits 14..0 only. The upper address bits are ignored.
- R6: A write that does not match the expected next step returns the decoder to idle without a command. That same write is not taken as the first step of a new sequence.
- R7: The writes AA@5555, 55@2AAA, 90@5555 set `id_mode` from the next cycle on.
- R8: `id_mode` is cleared by AA@5555, 55@2AAA, F0@5555. It is also cleared by a single F0 write to any address while no sequence is in progress. An F0 write that breaks a partial sequence only aborts that sequence.
- R9: While `id_mode` is high, `id_data` depends on `rd_addr`. At 0 it is 1F. At 1 it is 23, or 27 when TOP_BOOT=1. At 2 it is {7'b0, `boot_locked`}. At any other address it is 00. While `id_mode` is low, `id_data` is 00.
- R10: The boot region is the set of addresses whose bits above BOOT_AW-1 are all zero (TOP_BOOT=0) or all one (TOP_BOOT=1). A program into that region gives no `prog_pulse` while `boot_locked`=1 and `lock_override`=0. With `lock_override`=1 the program is issued.
- R11: `rst_n` low aborts any partial sequence, clears `id_mode` and holds all pulses low.
- R12: At most one of `prog_pulse`, `erase_pulse` and `lock_pulse` is high in any cycle, and each one lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write cycle offered |
| wr_ready | output | 1 | Write can be accepted (low while busy) |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Program/erase engine busy |
| boot_locked | input | 1 | Boot region lock state |
| lock_override | input | 1 | Bypass of the boot region lock |
| rd_addr | input | ADDR_W | Read address for identification bytes |
| id_data | output | 8 | Identification byte |
| id_mode | output | 1 | Identification mode active |
| prog_pulse | output | 1 | Byte program request |
| prog_addr | output | ADDR_W | Program target address |
| prog_data | output | 8 | Program data |
| erase_pulse | output | 1 | Chip erase request |
| erase_keep_boot | output | 1 | Erase must spare the boot region |
| lock_pulse | output | 1 | Boot region lock request |

## Verification
The bench sweeps all 256 values of the third (opcode) write. Only A0 may open a program. Only 90 may enter identification mode. A decoder with a loose opcode compare would raise a program pulse or set `id_mode` for a neighbouring value. Sequences are sent with the upper address bits set. Other sequences break at the sixth step, are interrupted by reset, or are offered while busy. A decoder that compared all address bits, accepted writes during busy, or restarted on the breaking write would then emit a command where none is due. The bench also checks that an F0 inside a partial sequence leaves identification mode active. Programs into a locked boot region, with and without the override, are checked together with the keep-boot flag on erase.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_KEY1, SQ_KEY2, SQ_PGM, SQ_EKEY0, SQ_EKEY1, SQ_EKEY2
  } seq_e;

  localparam int unsigned CMD_AW = 15;
  localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] KEY_A        = 8'hAA;
  localparam logic [7:0] KEY_B        = 8'h55;
  localparam logic [7:0] OP_PROG      = 8'hA0;
  localparam logic [7:0] OP_ERASE_PRE = 8'h80;
  localparam logic [7:0] OP_ID_ENTER  = 8'h90;
  localparam logic [7:0] OP_ID_EXIT   = 8'hF0;
  localparam logic [7:0] OP_ERASE_ALL = 8'h10;
  localparam logic [7:0] OP_LOCK      = 8'h40;
endpackage

// File: rtl/flash_boot_guard.sv
module flash_boot_guard #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned BOOT_AW  = 14,
  parameter bit          TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              locked,
  input  logic              override,
  output logic              deny,
  output logic              keep
);
  localparam int unsigned HI_W = ADDR_W - BOOT_AW;

  logic [HI_W-1:0] hi;
  logic            in_boot;

  assign hi = addr[ADDR_W-1:BOOT_AW];

  generate
    if (TOP_BOOT) begin : g_top
      assign in_boot = &hi;
    end else begin : g_bottom
      assign in_boot = ~|hi;
    end
  endgenerate

  assign keep = locked & ~override;
  assign deny = keep & in_boot;
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
  parameter int unsigned ADDR_W   = 20,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'h23
) (
  input  logic              id_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              locked,
  output logic [7:0]        id_data
);
  always_comb begin
    id_data = 8'h00;
    if (id_mode) begin
      if (rd_addr == ADDR_W'(0))      id_data = MFR_CODE;
      else if (rd_addr == ADDR_W'(1)) id_data = DEV_CODE;
      else if (rd_addr == ADDR_W'(2)) id_data = {7'b0, locked};
    end
  end

  // R9: nothing but zero leaves the table outside identification mode
  always_comb begin
    a_r9_quiet_outside: assert (id_mode || id_data == 8'h00);
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              deny,
  input  logic              keep_in,
  output logic              go_prog,
  output logic              go_erase,
  output logic              go_lock,
  output logic              keep_out,
  output logic              id_mode,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [7:0]        pgm_data
);
  seq_e st;
  logic hit_a, hit_b;

  assign hit_a = (addr[CMD_AW-1:0] == KEY_ADDR_A);
  assign hit_b = (addr[CMD_AW-1:0] == KEY_ADDR_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      id_mode  <= 1'b0;
      go_prog  <= 1'b0;
      go_erase <= 1'b0;
      go_lock  <= 1'b0;
      keep_out <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
    end else begin
      go_prog  <= 1'b0;
      go_erase <= 1'b0;
      go_lock  <= 1'b0;
      if (acc) begin
        st <= SQ_IDLE;
        case (st)
          SQ_IDLE: begin
            if (hit_a && data == KEY_A) st <= SQ_KEY1;
            else if (data == OP_ID_EXIT) id_mode <= 1'b0;
          end
          SQ_KEY1: if (hit_b && data == KEY_B) st <= SQ_KEY2;
          SQ_KEY2: begin
            if (hit_a) begin
              case (data)
                OP_PROG:      st <= SQ_PGM;
                OP_ERASE_PRE: st <= SQ_EKEY0;
                OP_ID_ENTER:  id_mode <= 1'b1;
                OP_ID_EXIT:   id_mode <= 1'b0;
                default:      ;
              endcase
            end
          end
          SQ_PGM: begin
            go_prog  <= ~deny;
            pgm_addr <= addr;
            pgm_data <= data;
          end
          SQ_EKEY0: if (hit_a && data == KEY_A) st <= SQ_EKEY1;
          SQ_EKEY1: if (hit_b && data == KEY_B) st <= SQ_EKEY2;
          SQ_EKEY2: begin
            if (hit_a && data == OP_ERASE_ALL) begin
              go_erase <= 1'b1;
              keep_out <= keep_in;
            end
            if (hit_a && data == OP_LOCK) go_lock <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R12: command pulses never coincide
  a_r12_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_prog, go_erase, go_lock}));

  // R12: a pulse lasts one cycle
  a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_erase || go_lock) |=> !(go_prog || go_erase || go_lock));

  // R1: a command only follows an accepted write
  a_r1_cmd_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_erase || go_lock) |-> $past(acc));

  // R1: identification mode only moves on an accepted write
  a_r1_id_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc) |-> $stable(id_mode));

  // R6: leaving a sequence always passes through idle first
  a_r6_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && st == SQ_KEY1) |=> (st == SQ_IDLE || st == SQ_KEY2));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned BOOT_AW    = 14,
  parameter bit          TOP_BOOT   = 1'b0,
  parameter logic [7:0]  MFR_CODE   = 8'h1F,
  parameter logic [7:0]  DEV_BOTTOM = 8'h23,
  parameter logic [7:0]  DEV_TOP    = 8'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              boot_locked,
  input  logic              lock_override,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        id_data,
  output logic              id_mode,
  output logic              prog_pulse,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              erase_pulse,
  output logic              erase_keep_boot,
  output logic              lock_pulse
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOTTOM;

  logic acc, deny, keep;

  assign wr_ready = ~busy;
  assign acc      = wr_valid & wr_ready;

  flash_boot_guard #(
    .ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .TOP_BOOT(TOP_BOOT)
  ) u_guard (
    .addr(wr_addr), .locked(boot_locked), .override(lock_override),
    .deny(deny), .keep(keep)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .acc(acc), .addr(wr_addr), .data(wr_data),
    .deny(deny), .keep_in(keep),
    .go_prog(prog_pulse), .go_erase(erase_pulse), .go_lock(lock_pulse),
    .keep_out(erase_keep_boot), .id_mode(id_mode),
    .pgm_addr(prog_addr), .pgm_data(prog_data)
  );

  flash_id_rom #(
    .ADDR_W(ADDR_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_rom (
    .id_mode(id_mode), .rd_addr(rd_addr), .locked(boot_locked),
    .id_data(id_data)
  );

  // R10: a protected program never reaches the engine
  a_r10_boot_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_pulse && $past(boot_locked && !lock_override)) |->
      !(TOP_BOOT ? (&prog_addr[ADDR_W-1:BOOT_AW])
                 : (~|prog_addr[ADDR_W-1:BOOT_AW])));

  // R1: nothing is issued the cycle after a busy write slot
  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !(prog_pulse || erase_pulse || lock_pulse));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int unsigned AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy = 1'b0;
  logic          boot_locked = 1'b0;
  logic          lock_override = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    id_data;
  logic          id_mode;
  logic          prog_pulse;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          erase_pulse;
  logic          erase_keep_boot;
  logic          lock_pulse;

  int checks = 0;
  int failures = 0;
  logic gp, ge, gl;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    gp = prog_pulse; ge = erase_pulse; gl = lock_pulse;
  endtask

  task automatic keys(input logic [AW-1:0] hi);
    wr(hi | 20'h05555, 8'hAA);
    wr(hi | 20'h02AAA, 8'h55);
  endtask

  task automatic six(input logic [7:0] last);
    keys(0); wr(20'h05555, 8'h80); keys(0); wr(20'h05555, last);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!id_mode && !prog_pulse && !erase_pulse && !lock_pulse, "R11 reset", id_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2, R7, R8: sweep of every opcode byte
    for (int v = 0; v < 256; v++) begin
      keys(0);
      wr(20'h05555, 8'(v));
      chk(id_mode == (v == 8'h90), "R7 opcode sweep id", id_mode, v == 8'h90);
      wr(20'h12345, 8'h5A);
      chk(gp == (v == 8'hA0), "R2 opcode sweep prog", gp, v == 8'hA0);
      if (v == 8'hA0)
        chk(prog_addr == 20'h12345 && prog_data == 8'h5A, "R2 payload", prog_data, 8'h5A);
      if (id_mode) begin
        wr(20'h00777, 8'hF0);
        chk(!id_mode, "R8 single exit", id_mode, 0);
      end
    end

    // R5: upper address bits ignored
    keys(20'hF8000); wr(20'hA5555, 8'hA0); wr(20'hFFFFF, 8'h00);
    chk(gp && prog_addr == 20'hFFFFF, "R5 high bits", prog_addr, 20'hFFFFF);

    // R3 / R4
    six(8'h10);
    chk(ge && !gl && !gp, "R3 erase", ge, 1);
    chk(!erase_keep_boot, "R3 keep unlocked", erase_keep_boot, 0);
    six(8'h40);
    chk(gl && !ge, "R4 lock", gl, 1);
    // R6: broken sixth step, then the breaking write is not a start
    six(8'h11);
    chk(!ge && !gl, "R6 bad last", ge, 0);
    keys(0); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(20'h00500, 8'h01);
    chk(!gp, "R6 no restart", gp, 0);
    keys(0); wr(20'h02AAA, 8'hA0); wr(20'h04000, 8'h01);
    chk(!gp, "R6 wrong addr", gp, 0);

    // R7/R8/R9 identification reads and exits
    boot_locked = 1'b1;
    keys(0); wr(20'h05555, 8'h90);
    for (int ra = 0; ra < 5; ra++) begin
      rd_addr = AW'(ra);
      #1;
      chk(id_data == (ra == 0 ? 8'h1F : ra == 1 ? 8'h23 : ra == 2 ? 8'h01 : 8'h00),
          "R9 id read", id_data, ra);
    end
    boot_locked = 1'b0; rd_addr = 20'd2; #1;
    chk(id_data == 8'h00, "R9 lock bit clear", id_data, 0);
    wr(20'h05555, 8'hAA); wr(20'h00000, 8'hF0);
    chk(id_mode, "R8 F0 in partial", id_mode, 1);
    keys(0); wr(20'h05555, 8'hF0);
    chk(!id_mode, "R8 long exit", id_mode, 0);
    rd_addr = 20'd0; #1;
    chk(id_data == 8'h00, "R9 off mode", id_data, 0);

    // R10 boot protection
    boot_locked = 1'b1;
    keys(0); wr(20'h05555, 8'hA0); wr(20'h00100, 8'h33);
    chk(!gp, "R10 locked boot", gp, 0);
    keys(0); wr(20'h05555, 8'hA0); wr(20'h04100, 8'h33);
    chk(gp, "R10 outside boot", gp, 1);
    lock_override = 1'b1;
    keys(0); wr(20'h05555, 8'hA0); wr(20'h00100, 8'h33);
    chk(gp, "R10 override", gp, 1);
    lock_override = 1'b0;
    six(8'h10);
    chk(ge && erase_keep_boot, "R3 keep locked", erase_keep_boot, 1);
    boot_locked = 1'b0;

    // R1 busy back-pressure
    busy = 1'b1; #1;
    chk(!wr_ready, "R1 ready low", wr_ready, 0);
    wr(20'h05555, 8'hAA);
    busy = 1'b0;
    wr(20'h02AAA, 8'h55); wr(20'h05555, 8'hA0); wr(20'h04200, 8'h44);
    chk(!gp, "R1 busy ignored", gp, 0);

    // R11 reset aborts partial sequence and clears id mode
    keys(0); wr(20'h05555, 8'h90);
    keys(0); wr(20'h05555, 8'hA0);
    @(negedge clk); rst_n = 1'b0; @(negedge clk);
    chk(!id_mode, "R11 id cleared", id_mode, 0);
    rst_n = 1'b1;
    wr(20'h04300, 8'h66);
    chk(!gp, "R11 abort", gp, 0);
    // R12 pulse width
    keys(0); wr(20'h05555, 8'hA0); wr(20'h04400, 8'h77);
    @(negedge clk);
    chk(gp && !prog_pulse, "R12 one cycle", prog_pulse, 0);

    finish_run();
  end
endmodule